// File: doc/BRIEF.md
# Bus-Cycle Stretcher

This block lengthens external bus cycles so that a processor core can reach slow off-chip memory and I/O. Software programs a 16-bit wait-state register that holds five 3-bit base counts and one extended-addressing bit, plus a separate control register whose bit 0 selects a x1 or x2 multiplier. When the core issues an external access, the block works out from the address space and the address which of the five counts applies. It scales that count and holds `acc_ready` low for the resulting number of cycles.

The count is loaded into a down-counter when the access is accepted. After that point, register writes and further requests have no effect on the access in flight. Both registers can be read back through the configuration port.

Top module: `bus_stretch_top`

## Requirements
- R1: The reset is synchronous and active high. After reset the wait-state register reads 0x7FFF, the control register reads 0x0000 and `acc_ready` is 1. While reset is held, `cfg_rdata` is 0. Every external access then gets 7 wait cycles.
- R2: An access with `acc_space` = 2 or 3 (I/O) uses the base count in wait-state register bits 14:12, whatever the address.
- R3: An access with `acc_space` = 1 (data) uses bits 11:9 when `acc_addr[15]` is 1 and bits 8:6 when it is 0.
- R4: An access with `acc_space` = 0 (program) while register bit 15 is 0 uses bits 5:3 when `acc_addr[15]` is 1 and bits 2:0 otherwise. Address bits 17:16 are ignored.
- R5: While register bit 15 is 1, a program access uses bits 2:0 for every address from 0x00000 to 0x3FFFF, and bits 5:3 have no effect.
- R6: Control register bit 0 = 1 doubles the selected base count, so an access can reach 14 wait cycles. Control bits 15:1 are ignored and read as 0.
- R7: A request is accepted on a clock edge where `acc_req` = 1 and `acc_ready` = 1. `acc_ready` is then low for exactly N cycles after that edge, where N is the scaled count. If N = 0, `acc_ready` stays high.
- R8: A request made while `acc_ready` is low is ignored and does not lengthen the current access.
- R9: A register write during an access, or in the cycle that accepts it, does not change that access. The next accepted request uses the new value.
- R10: `cfg_rdata` is registered. One cycle after an edge, it shows the register selected by `cfg_sel` at that edge (0 = wait-state register, all 16 bits; 1 = control register). If a write to the same register happens at that edge, it shows the value from before the write. A write with `cfg_sel` = 0 replaces all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 wait-state, 1 control |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Registered read data |
| acc_req | input | 1 | External access request |
| acc_space | input | 2 | 0 program, 1 data, 2 or 3 I/O |
| acc_addr | input | 18 | Access address; data and I/O use bits 15:0 |
| acc_ready | output | 1 | High when no wait cycles remain |

## Verification
Both outputs come from a single register stage. The effect of any edge therefore shows on `acc_ready` and `cfg_rdata` one cycle later, and the bench samples them 1 ns after each rising edge. The bench holds a behavioural model that it updates from the inputs driven at each edge, and it compares both outputs on every clock. Each access also has its low stretch of `acc_ready` counted cycle by cycle against the wait count expected from the requirements. This makes it possible to observe off-by-one stretches, ignored requests and write-during-access cases at the ports.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  typedef enum logic [1:0] {
    SP_PROG   = 2'd0,
    SP_DATA   = 2'd1,
    SP_IO     = 2'd2,
    SP_IO_ALT = 2'd3
  } space_e;

  // field slots inside the wait-state register; order is decoded by bsw_decode
  localparam int F_PROG_LO = 0;
  localparam int F_PROG_HI = 1;
  localparam int F_DATA_LO = 2;
  localparam int F_DATA_HI = 3;
  localparam int F_IO      = 4;
  localparam int NUM_SLOTS = 5;
endpackage

// File: rtl/bsw_regs.sv
module bsw_regs #(
  parameter int REG_W   = 16,
  parameter int FIELD_W = 3,
  parameter int NFIELDS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] wsr,
  output logic             mult,
  output logic [REG_W-1:0] rdata
);
  localparam int FBITS = FIELD_W * NFIELDS;
  localparam logic [REG_W-1:0] WSR_RST = {{(REG_W-FBITS){1'b0}}, {FBITS{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      wsr   <= WSR_RST;
      mult  <= 1'b0;
      rdata <= '0;
    end else begin
      rdata <= sel ? {{(REG_W-1){1'b0}}, mult} : wsr;
      if (we) begin
        if (sel) mult <= wdata[0];
        else     wsr  <= wdata;
      end
    end
  end

  // R1
  reset_values_chk: assert property (@(posedge clk)
    $past(rst) |-> (wsr == WSR_RST && mult == 1'b0));

  // R10
  write_applies_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !sel) |=> (wsr == $past(wdata)));
endmodule

// File: rtl/bsw_decode.sv
module bsw_decode
  import bsw_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int FIELD_W  = 3,
  parameter int NFIELDS  = 5,
  parameter int ADDR_W   = 18,
  parameter int LOCAL_AW = 16,
  parameter int CNT_W    = FIELD_W + 1
) (
  input  logic [REG_W-1:0]  wsr,
  input  logic              mult,
  input  logic [1:0]        space,
  input  logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  load_cnt
);
  localparam int HALF_BIT = LOCAL_AW - 1;

  logic [FIELD_W-1:0] field [NFIELDS];
  logic [FIELD_W-1:0] base;
  logic               xbit;
  logic               upper;

  genvar gi;
  generate
    for (gi = 0; gi < NFIELDS; gi++) begin : g_field
      assign field[gi] = wsr[gi*FIELD_W +: FIELD_W];
    end
  endgenerate

  assign xbit  = wsr[REG_W-1];
  assign upper = addr[HALF_BIT];

  always_comb begin
    unique case (space_e'(space))
      SP_PROG: base = (!xbit && upper) ? field[F_PROG_HI] : field[F_PROG_LO];
      SP_DATA: base = upper ? field[F_DATA_HI] : field[F_DATA_LO];
      default: base = field[F_IO];
    endcase
    load_cnt = mult ? {base, 1'b0} : {1'b0, base};
  end
endmodule

// File: rtl/bsw_counter.sv
module bsw_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [CNT_W-1:0] load_cnt,
  output logic             ready
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b1;
    end else if (cnt != '0) begin
      cnt   <= cnt - 1'b1;
      ready <= (cnt == CNT_W'(1));
    end else if (req) begin
      cnt   <= load_cnt;
      ready <= (load_cnt == '0);
    end
  end

  // R8
  ignore_busy_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && req) |=> (cnt == $past(cnt) - 1'b1));

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && req && load_cnt != '0) |=> !ready);

  // R7
  zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && req && load_cnt == '0) |=> ready);
endmodule

// File: rtl/bus_stretch_top.sv
module bus_stretch_top #(
  parameter int ADDR_W   = 18,
  parameter int REG_W    = 16,
  parameter int FIELD_W  = 3,
  parameter int NFIELDS  = 5,
  parameter int LOCAL_AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              acc_req,
  input  logic [1:0]        acc_space,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_ready
);
  localparam int CNT_W = FIELD_W + 1;

  logic [REG_W-1:0] wsr;
  logic             mult;
  logic [CNT_W-1:0] load_cnt;

  bsw_regs #(.REG_W(REG_W), .FIELD_W(FIELD_W), .NFIELDS(NFIELDS)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .wsr(wsr), .mult(mult), .rdata(cfg_rdata)
  );

  bsw_decode #(.REG_W(REG_W), .FIELD_W(FIELD_W), .NFIELDS(NFIELDS),
               .ADDR_W(ADDR_W), .LOCAL_AW(LOCAL_AW), .CNT_W(CNT_W)) u_decode (
    .wsr(wsr), .mult(mult), .space(acc_space), .addr(acc_addr), .load_cnt(load_cnt)
  );

  bsw_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .req(acc_req), .load_cnt(load_cnt), .ready(acc_ready)
  );

  // R6
  mult_even_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_ready && acc_req && mult) |=> (acc_ready || !$past(load_cnt[0])));
endmodule

// File: tb/bus_stretch_top_bench.sv
module bus_stretch_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        acc_req = 1'b0;
  logic [1:0]  acc_space = '0;
  logic [17:0] acc_addr = '0;
  logic        acc_ready;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";

  // reference state
  int m_wsr = 0, m_mult = 0, m_cnt = 0, m_rdata = 0;

  always #2.5 clk = ~clk;

  bus_stretch_top u_bus_stretch_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_req(acc_req),
    .acc_space(acc_space), .acc_addr(acc_addr), .acc_ready(acc_ready)
  );

  function automatic int fld(int w, int idx);
    return (w >> (idx * 3)) & 7;
  endfunction

  function automatic int waits(int w, int m, int sp, int a);
    int b;
    if (sp >= 2)      b = fld(w, 4);
    else if (sp == 1) b = ((a >> 15) & 1) ? fld(w, 3) : fld(w, 2);
    else if ((w >> 15) & 1) b = fld(w, 0);
    else              b = ((a >> 15) & 1) ? fld(w, 1) : fld(w, 0);
    return m ? 2 * b : b;
  endfunction

  task automatic check(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  task automatic step(logic we, logic sel, logic [15:0] wd, logic rq,
                      logic [1:0] sp, logic [17:0] ad);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    acc_req = rq; acc_space = sp; acc_addr = ad;
    @(posedge clk);
    if (rst) begin
      m_wsr = 16'h7FFF; m_mult = 0; m_cnt = 0; m_rdata = 0;
    end else begin
      m_rdata = sel ? m_mult : m_wsr;
      if (m_cnt != 0) m_cnt--;
      else if (rq) m_cnt = waits(m_wsr, m_mult, sp, ad);
      if (we) begin
        if (sel) m_mult = wd[0];
        else     m_wsr = wd;
      end
    end
    #1;
    check("ready", acc_ready, (m_cnt == 0));
    check("rdata", cfg_rdata, m_rdata);
  endtask

  task automatic idle();
    step(0, cfg_sel, 0, 0, 0, 0);
  endtask

  task automatic wr(logic sel, logic [15:0] v);
    step(1, sel, v, 0, 0, 0);
  endtask

  task automatic rd(logic sel, int exp);
    step(0, sel, 0, 0, 0, 0);
    check("readback", cfg_rdata, exp);
  endtask

  // issue one access; hold keeps the request asserted during waits (R8)
  task automatic access(logic [1:0] sp, logic [17:0] ad, int exp_w, bit hold);
    int lows = 0;
    step(0, 0, 0, 1, sp, ad);
    while (!acc_ready && lows < 40) begin
      lows++;
      step(0, 0, 0, hold, sp, ad);
    end
    check("wait_len", lows, exp_w);
    idle();
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired got %0d exp <100000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tag = "R1";
    rst = 1'b1;
    repeat (3) step(0, 0, 0, 0, 0, 0);
    rst = 1'b0;
    rd(0, 16'h7FFF);
    rd(1, 0);
    access(0, 18'h00010, 7, 0);
    access(2, 18'h0FFFF, 7, 0);

    tag = "R10";
    wr(0, 16'h58D1);
    rd(0, 16'h58D1);
    wr(1, 16'hFFFE);
    rd(1, 0);
    step(1, 0, 16'h1234, 0, 0, 0);  // same-edge write shows old value
    check("old_on_write", cfg_rdata, 16'h58D1);
    wr(0, 16'h58D1);

    tag = "R2";
    access(2, 18'h01234, 5, 0);
    access(3, 18'h0F000, 5, 0);
    tag = "R3";
    access(1, 18'h08000, 4, 0);
    access(1, 18'h07FFF, 3, 0);
    tag = "R4";
    access(0, 18'h38000, 2, 0);
    access(0, 18'h07FFF, 1, 0);
    access(0, 18'h2FFFF, 2, 0);
    tag = "R5";
    wr(0, 16'hD8D1);
    access(0, 18'h38000, 1, 0);
    access(0, 18'h0FFFF, 1, 0);
    access(0, 18'h3FFFF, 1, 0);

    tag = "R6";
    wr(1, 16'h0001);
    rd(1, 1);
    access(2, 18'h00000, 10, 0);
    wr(0, 16'h7FFF);
    access(1, 18'h0C000, 14, 0);
    wr(1, 16'h0000);

    tag = "R7";
    wr(0, 16'h0000);
    access(0, 18'h00100, 0, 0);
    access(1, 18'h08100, 0, 0);
    wr(0, 16'h0003);
    access(0, 18'h00001, 3, 0);

    tag = "R8";
    wr(0, 16'h4000);
    access(2, 18'h00001, 4, 1);
    wr(0, 16'h0005);
    access(0, 18'h00002, 5, 1);

    tag = "R9";
    wr(0, 16'h0002);
    step(1, 0, 16'h0006, 1, 0, 0);  // write in the accepting cycle
    begin
      int lows = 0;
      while (!acc_ready && lows < 40) begin
        lows++;
        if (lows == 1) wr(0, 16'h0007);
        else idle();
      end
      check("wait_len_during_write", lows, 2);
    end
    access(0, 18'h00000, 7, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule